// File: doc/BRIEF.md
# Bit Test, Rotate and Shift Unit

This block is the execution stage for the prefixed opcode page of an 8-bit processor that holds the rotate, shift and single-bit instructions. Each cycle the caller may present one request. A request carries the second opcode byte, the operand byte, the accumulator and the current flag byte. One clock later the unit returns the result byte, the new accumulator, the new flag byte and two write enables. One enable is for the operand destination and one is for the accumulator.

The opcode byte is decoded in three fields. Bits 7:6 pick the group and bits 5:3 pick either the bit number or the shift kind. Bits 2:0 name the destination register. This unit does not use that field; it is left to the register file. The unit also runs the two 4-bit nibble rotates, which exchange nibbles between the accumulator and a memory byte. The caller selects them with a request-kind input rather than with an opcode. Fetching operands, indexed addressing and instruction timing are handled by the surrounding core.

Top module: `bsu_top`

## Requirements
- R1: While reset is asserted, and for the cycles of its synchronous release, `out_valid`, `out_data_wr` and `out_acc_wr` are 0.
- R2: A request accepted with `in_valid`=1 at a clock edge shows its results on the outputs after that edge, with `out_valid`=1. With `in_valid`=0, `out_valid` is 0 one edge later.
- R3: With `in_kind`=0 (page request), `in_op[7:6]` selects the group: 00 rotate/shift, 01 bit test, 10 bit clear, 11 bit set. Only the bit test leaves `out_data_wr` at 0. `out_acc_wr` is 0 for every page request and `out_acc` equals `in_acc`.
- R4: In the rotate/shift group, `in_op[5:3]` picks the kind: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 arithmetic shift left, 5 arithmetic shift right keeping bit 7, 6 shift left filling bit 0 with 1, 7 logical shift right. `out_data` is the shifted byte.
- R5: After a rotate/shift, the flags are set as follows. Sign (bit 7) is result bit 7. Zero (bit 6) is set for a zero result. Parity (bit 2) is 1 when the result has an even number of ones. Half-carry (bit 4) and subtract (bit 1) are 0. Carry (bit 0) is the bit shifted out. Flag bits 5 and 3 keep their input values.
- R6: A bit test of bit `in_op[5:3]` sets zero to the inverse of that operand bit, sets half-carry to 1 and subtract to 0, and keeps every other flag bit. `out_data` equals the operand and nothing is written back.
- R7: Bit clear and bit set force operand bit `in_op[5:3]` to 0 or 1 respectively. All other bits are unchanged, and the flag byte is passed through unchanged.
- R8: Nibble rotate left (`in_kind`=1) gives a new memory byte of {mem low, acc low} and a new accumulator of {acc high, mem high}.
- R9: Nibble rotate right (`in_kind`=2) gives a new memory byte of {acc low, mem high} and a new accumulator of {acc high, mem low}.
- R10: Both nibble rotates assert both write enables. They take sign, zero and parity from the new accumulator, clear half-carry and subtract, and keep carry and flag bits 5 and 3.
- R11: `in_kind`=3 is inert. Both write enables are 0, the flags equal `in_flags`, and `out_data` and `out_acc` equal the inputs.
- R12: While `in_valid` is 0, `out_data`, `out_acc` and `out_flags` hold their previous values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_kind | input | 2 | 0 page op, 1 nibble left, 2 nibble right, 3 none |
| in_op | input | 8 | Second opcode byte |
| in_data | input | W | Operand or memory byte |
| in_acc | input | W | Accumulator |
| in_flags | input | 8 | Current flag byte |
| out_valid | output | 1 | Result strobe |
| out_data | output | W | Result / new memory byte |
| out_acc | output | W | New accumulator |
| out_flags | output | 8 | New flag byte |
| out_data_wr | output | 1 | Write back operand result |
| out_acc_wr | output | 1 | Write back accumulator |

## Verification
The bench builds the unit at its default data width of 8. At that width the opcode page has only 256 codes, so every one of them is applied against ten operand patterns and three flag bytes. This covers all carry-in and carry-out combinations and all eight bit positions, and it includes the zero-result and parity edge cases. The nibble rotates are swept over all 256 memory bytes against several accumulator values. Idle cycles with changing inputs confirm that the result registers hold.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  localparam int FLAG_W = 8;
  localparam int F_S = 7;
  localparam int F_Z = 6;
  localparam int F_H = 4;
  localparam int F_P = 2;
  localparam int F_N = 1;
  localparam int F_C = 0;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLR   = 2'b10,
    GRP_SET   = 2'b11
  } grp_e;

  typedef enum logic [2:0] {
    SH_RLC = 3'd0,
    SH_RRC = 3'd1,
    SH_RL  = 3'd2,
    SH_RR  = 3'd3,
    SH_SLA = 3'd4,
    SH_SRA = 3'd5,
    SH_SL1 = 3'd6,
    SH_SRL = 3'd7
  } shk_e;

  typedef enum logic [1:0] {
    REQ_PAGE  = 2'd0,
    REQ_NIB_L = 2'd1,
    REQ_NIB_R = 2'd2,
    REQ_NONE  = 2'd3
  } req_e;

endpackage

// File: rtl/bsu_shift.sv
module bsu_shift
  import bsu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  input  logic         cin,
  input  logic [2:0]   kind,
  output logic [W-1:0] res,
  output logic         cout
);

  always_comb begin
    res  = val;
    cout = 1'b0;
    unique case (shk_e'(kind))
      SH_RLC: begin res = {val[W-2:0], val[W-1]}; cout = val[W-1]; end
      SH_RRC: begin res = {val[0], val[W-1:1]};   cout = val[0];   end
      SH_RL:  begin res = {val[W-2:0], cin};      cout = val[W-1]; end
      SH_RR:  begin res = {cin, val[W-1:1]};      cout = val[0];   end
      SH_SLA: begin res = {val[W-2:0], 1'b0};     cout = val[W-1]; end
      SH_SRA: begin res = {val[W-1], val[W-1:1]}; cout = val[0];   end
      SH_SL1: begin res = {val[W-2:0], 1'b1};     cout = val[W-1]; end
      SH_SRL: begin res = {1'b0, val[W-1:1]};     cout = val[0];   end
      default: begin res = val; cout = 1'b0; end
    endcase
  end

endmodule

// File: rtl/bsu_bitop.sv
module bsu_bitop
  import bsu_pkg::*;
#(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     val,
  input  logic [IDX_W-1:0] idx,
  input  logic             set_not_clr,
  output logic [W-1:0]     res,
  output logic             bit_val
);

  logic [W-1:0] mask;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (idx == IDX_W'(i));
  end

  assign bit_val = |(val & mask);
  assign res     = set_not_clr ? (val | mask) : (val & ~mask);

endmodule

// File: rtl/bsu_nibble.sv
module bsu_nibble #(
  parameter int W = 8,
  localparam int H = W / 2
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mem,
  input  logic         left,
  output logic [W-1:0] acc_n,
  output logic [W-1:0] mem_n
);

  always_comb begin
    if (left) begin
      mem_n = {mem[H-1:0], acc[H-1:0]};
      acc_n = {acc[W-1:H], mem[W-1:H]};
    end else begin
      mem_n = {acc[H-1:0], mem[W-1:H]};
      acc_n = {acc[W-1:H], mem[H-1:0]};
    end
  end

endmodule

// File: rtl/bsu_top.sv
module bsu_top
  import bsu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_kind,
  input  logic [7:0]        in_op,
  input  logic [W-1:0]      in_data,
  input  logic [W-1:0]      in_acc,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  output logic [W-1:0]      out_data,
  output logic [W-1:0]      out_acc,
  output logic [FLAG_W-1:0] out_flags,
  output logic              out_data_wr,
  output logic              out_acc_wr
);

  localparam int IDX_W = $clog2(W);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // datapath units
  logic [W-1:0] sh_res, bit_res, nib_acc, nib_mem;
  logic         sh_cout, bit_val;
  grp_e         grp;
  req_e         kind;

  assign grp  = grp_e'(in_op[7:6]);
  assign kind = req_e'(in_kind);

  bsu_shift #(.W(W)) u_shift (
    .val  (in_data),
    .cin  (in_flags[F_C]),
    .kind (in_op[5:3]),
    .res  (sh_res),
    .cout (sh_cout)
  );

  bsu_bitop #(.W(W)) u_bitop (
    .val         (in_data),
    .idx         (in_op[3 +: IDX_W]),
    .set_not_clr (in_op[6]),
    .res         (bit_res),
    .bit_val     (bit_val)
  );

  bsu_nibble #(.W(W)) u_nib (
    .acc   (in_acc),
    .mem   (in_data),
    .left  (kind == REQ_NIB_L),
    .acc_n (nib_acc),
    .mem_n (nib_mem)
  );

  function automatic logic [FLAG_W-1:0] szp_flags(input logic [W-1:0] v,
                                                  input logic [FLAG_W-1:0] f);
    logic [FLAG_W-1:0] r;
    r      = f;
    r[F_S] = v[W-1];
    r[F_Z] = (v == '0);
    r[F_H] = 1'b0;
    r[F_P] = ~^v;
    r[F_N] = 1'b0;
    return r;
  endfunction

  // next state
  logic [W-1:0]      n_data, n_acc;
  logic [FLAG_W-1:0] n_flags;
  logic              n_dwr, n_awr;

  always_comb begin
    n_data  = in_data;
    n_acc   = in_acc;
    n_flags = in_flags;
    n_dwr   = 1'b0;
    n_awr   = 1'b0;
    unique case (kind)
      REQ_PAGE: begin
        unique case (grp)
          GRP_SHIFT: begin
            n_data       = sh_res;
            n_flags      = szp_flags(sh_res, in_flags);
            n_flags[F_C] = sh_cout;
            n_dwr        = 1'b1;
          end
          GRP_TEST: begin
            n_flags[F_Z] = ~bit_val;
            n_flags[F_H] = 1'b1;
            n_flags[F_N] = 1'b0;
          end
          default: begin
            n_data = bit_res;
            n_dwr  = 1'b1;
          end
        endcase
      end
      REQ_NIB_L, REQ_NIB_R: begin
        n_data  = nib_mem;
        n_acc   = nib_acc;
        n_flags = szp_flags(nib_acc, in_flags);
        n_dwr   = 1'b1;
        n_awr   = 1'b1;
      end
      default: ;
    endcase
  end

  // registers: control with reset, datapath with clock enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid   <= 1'b0;
      out_data_wr <= 1'b0;
      out_acc_wr  <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_data_wr <= in_valid & n_dwr;
      out_acc_wr  <= in_valid & n_awr;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_data  <= n_data;
      out_acc   <= n_acc;
      out_flags <= n_flags;
    end
  end

  // assertions
  always_comb begin
    if (rst_sync_n) begin
      a_r2_wr_needs_valid: assert (!(out_data_wr || out_acc_wr) || out_valid);
    end
  end

  a_r5_shift_flags: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_kind == 2'd0 && in_op[7:6] == 2'b00)
      |=> (out_data_wr && !out_flags[F_H] && !out_flags[F_N]));

  a_r6_test_no_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_kind == 2'd0 && in_op[7:6] == 2'b01)
      |=> (!out_data_wr && out_flags[F_H] && out_flags[F_C] == $past(in_flags[F_C])));

  a_r7_bitmod_flags: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_kind == 2'd0 && in_op[7] == 1'b1)
      |=> (out_data_wr && out_flags == $past(in_flags)));

  a_r10_nibble_carry: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (in_kind == 2'd1 || in_kind == 2'd2))
      |=> (out_acc_wr && out_flags[F_C] == $past(in_flags[F_C])));

  a_r11_none_inert: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_kind == 2'd3)
      |=> (!out_data_wr && !out_acc_wr && out_flags == $past(in_flags)));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(out_data) && $stable(out_flags) && !out_valid));

endmodule

// File: tb/tb_bsu_top.sv
module tb_bsu_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [1:0] in_kind;
  logic [7:0] in_op, in_data, in_acc, in_flags;
  logic       out_valid, out_data_wr, out_acc_wr;
  logic [7:0] out_data, out_acc, out_flags;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  bsu_top #(.W(8)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_op(in_op), .in_data(in_data), .in_acc(in_acc), .in_flags(in_flags),
    .out_valid(out_valid), .out_data(out_data), .out_acc(out_acc),
    .out_flags(out_flags), .out_data_wr(out_data_wr), .out_acc_wr(out_acc_wr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h (kind=%0d op=%h data=%h acc=%h f=%h)",
               req, act, exp, in_kind, in_op, in_data, in_acc, in_flags);
    end
  endtask

  function automatic logic [7:0] zsp(input logic [7:0] r, input logic [7:0] f);
    logic [7:0] e;
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += r[i];
    e = f;
    e[7] = (r >= 8'd128);
    e[6] = (r == 8'd0);
    e[4] = 1'b0;
    e[2] = (ones % 2 == 0);
    e[1] = 1'b0;
    return e;
  endfunction

  // apply one request at a falling edge, check at the next falling edge
  task automatic apply(input logic [1:0] k, input logic [7:0] op,
                       input logic [7:0] v, input logic [7:0] a, input logic [7:0] f);
    logic [7:0] ed, ea, ef;
    logic       edw, eaw;
    int         s, c, cin, r;
    string      tag_d, tag_f, tag_c;
    in_valid = 1'b1; in_kind = k; in_op = op; in_data = v; in_acc = a; in_flags = f;
    ed = v; ea = a; ef = f; edw = 1'b0; eaw = 1'b0;
    s = int'(op[5:3]); cin = int'(f[0]);
    tag_d = "R11"; tag_f = "R11"; tag_c = "R11";
    if (k == 2'd0) begin
      tag_c = "R3";
      case (op[7:6])
        2'b00: begin
          tag_d = "R4"; tag_f = "R5";
          case (s)
            0: begin r = (v * 2) % 256 + v / 128;   c = v / 128; end
            1: begin r = v / 2 + (v % 2) * 128;     c = v % 2;   end
            2: begin r = (v * 2) % 256 + cin;       c = v / 128; end
            3: begin r = v / 2 + cin * 128;         c = v % 2;   end
            4: begin r = (v * 2) % 256;             c = v / 128; end
            5: begin r = v / 2 + (v / 128) * 128;   c = v % 2;   end
            6: begin r = (v * 2) % 256 + 1;         c = v / 128; end
            default: begin r = v / 2;               c = v % 2;   end
          endcase
          ed = 8'(r); ef = zsp(ed, f); ef[0] = (c != 0); edw = 1'b1;
        end
        2'b01: begin
          tag_d = "R6"; tag_f = "R6";
          ef[6] = ((v >> s) % 2 == 0); ef[4] = 1'b1; ef[1] = 1'b0;
        end
        2'b10: begin
          tag_d = "R7"; tag_f = "R7";
          ed = ((v >> s) % 2 == 1) ? 8'(v - (1 << s)) : v; edw = 1'b1;
        end
        default: begin
          tag_d = "R7"; tag_f = "R7";
          ed = ((v >> s) % 2 == 0) ? 8'(v + (1 << s)) : v; edw = 1'b1;
        end
      endcase
    end else if (k == 2'd1) begin
      tag_d = "R8"; tag_f = "R10"; tag_c = "R10";
      ed = 8'((v % 16) * 16 + a % 16);
      ea = 8'((a / 16) * 16 + v / 16);
      ef = zsp(ea, f); edw = 1'b1; eaw = 1'b1;
    end else if (k == 2'd2) begin
      tag_d = "R9"; tag_f = "R10"; tag_c = "R10";
      ed = 8'((a % 16) * 16 + v / 16);
      ea = 8'((a / 16) * 16 + v % 16);
      ef = zsp(ea, f); edw = 1'b1; eaw = 1'b1;
    end
    @(negedge clk);
    chk(tag_d, {16'd0, out_data, out_acc}, {16'd0, ed, ea});
    chk(tag_f, {24'd0, out_flags}, {24'd0, ef});
    chk(tag_c, {29'd0, out_valid, out_data_wr, out_acc_wr}, {29'd0, 1'b1, edw, eaw});
    in_valid = 1'b0;
  endtask

  initial begin
    logic [7:0] vals [10] = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'h5A, 8'hA5, 8'h3C, 8'h7E, 8'h81, 8'h0F};
    logic [7:0] flg  [3]  = '{8'h00, 8'hFF, 8'h29};
    logic [7:0] accs [4]  = '{8'h00, 8'h9F, 8'h30, 8'hE7};
    logic [7:0] hd, hf, ha;
    rst_n = 1'b0; in_valid = 1'b0; in_kind = 2'd0; in_op = '0;
    in_data = '0; in_acc = '0; in_flags = '0;
    repeat (3) @(negedge clk);
    chk("R1", {29'd0, out_valid, out_data_wr, out_acc_wr}, 32'd0);
    in_valid = 1'b1;
    @(negedge clk);
    chk("R1", {29'd0, out_valid, out_data_wr, out_acc_wr}, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {29'd0, out_valid, out_data_wr, out_acc_wr}, 32'd0);

    for (int op = 0; op < 256; op++)
      for (int vi = 0; vi < 10; vi++)
        for (int fi = 0; fi < 3; fi++)
          apply(2'd0, 8'(op), vals[vi], 8'hC3, flg[fi]);

    for (int ai = 0; ai < 4; ai++)
      for (int m = 0; m < 256; m++) begin
        apply(2'd1, 8'h00, 8'(m), accs[ai], flg[m % 3]);
        apply(2'd2, 8'h00, 8'(m), accs[ai], flg[(m + 1) % 3]);
      end

    for (int vi = 0; vi < 10; vi++)
      apply(2'd3, 8'(vi * 25), vals[vi], accs[vi % 4], flg[vi % 3]);

    // hold while idle
    apply(2'd0, 8'h07, 8'h81, 8'h12, 8'h00);
    hd = out_data; hf = out_flags; ha = out_acc;
    in_valid = 1'b0; in_kind = 2'd1; in_op = 8'hFF; in_data = 8'h55;
    in_acc = 8'hAA; in_flags = 8'hFF;
    @(negedge clk);
    chk("R12", {8'd0, out_data, out_acc, out_flags}, {8'd0, hd, ha, hf});
    chk("R2", {31'd0, out_valid}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R12", {8'd0, out_data, out_acc, out_flags}, {8'd0, hd, ha, hf});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule